// File: doc/BRIEF.md
# Remappable Memory Map Decoder

This block turns every 16-bit CPU address into exactly one region select (at most one). The regions are on-chip RAM, the control register block, EEPROM, bootstrap ROM and the external bus. It also holds an 8-bit placement register. The CPU writes this register to move the RAM and the register block to other 4 KB blocks of the address space. While reset is held, the block samples the two mode pins. It keeps the resulting operating mode and three control bits until the next reset.

In the two normal modes (single chip and expanded), the placement register is protected. It takes a single write, and that write must arrive within the first 64 E-clock edges after reset ends. In the two special modes (bootstrap and test), it can be rewritten at any time. The placement of EEPROM and boot ROM depends on the latched mode. Addresses that hit no internal region go to the external bus only in modes that have one.

The design is synchronous to the E-clock and uses a synchronous active-low reset. Decoding is purely combinational from the address and the current state.

Top module: `mem_map_decode`

## Requirements
- R1: After reset the placement register holds $01. RAM (1 KB) therefore selects at $0000–$03FF and the 96-byte register block selects at $1000–$105F.
- R2: The placement register sits at byte offset $03D inside the register block. A write there sets the RAM base block from data bits 7:4 and the register base block from data bits 3:0, where the base address is the nibble times $1000.
- R3: In normal modes only the first accepted write changes the placement register. Any later write leaves the decode unchanged until the next reset.
- R4: In normal modes a write is accepted only on one of the first 64 rising clock edges after reset is released (edges 0 to 63). A write on edge 64 or later is ignored.
- R5: In special modes the placement register accepts every write, at any time after reset.
- R6: When RAM and the register block share a base block, offsets $000–$05F select the register block and offsets $060–$3FF select RAM.
- R7: EEPROM selects at offsets $E00–$FFF of block `ee_base` in expanded and test modes, and at $FE00–$FFFF in single-chip and bootstrap modes. It selects only when `ee_en` is 1.
- R8: Boot ROM selects at $BF00–$BFFF only when the latched mode is bootstrap.
- R9: The pins {mode_b, mode_a} are latched on reset edges: 10 = single chip, 11 = expanded, 00 = bootstrap, 01 = test. The outputs {ctl_rboot, ctl_smod, ctl_mda} are 000, 001, 110 and 011 for these modes. Pin changes after reset have no effect.
- R10: `sel` is one-hot or zero, with bit 0 = registers, bit 1 = RAM, bit 2 = boot ROM, bit 3 = EEPROM and bit 4 = external. The priority order is registers, RAM, boot ROM, EEPROM, external. An address with no internal hit selects external in expanded and test modes, and selects nothing in single-chip and bootstrap modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | E-clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_b | input | 1 | Upper mode pin, sampled during reset |
| mode_a | input | 1 | Lower mode pin, sampled during reset |
| addr | input | 16 | CPU address |
| wr | input | 1 | 1 = write cycle |
| wdata | input | 8 | CPU write data |
| ee_base | input | 4 | EEPROM block number for expanded and test modes |
| ee_en | input | 1 | EEPROM enable |
| sel | output | 5 | One-hot region select (see R10) |
| ctl_rboot | output | 1 | Latched boot-ROM control bit |
| ctl_smod | output | 1 | Latched special-mode bit |
| ctl_mda | output | 1 | Latched mode-A bit |

## Verification
Two functions can meet in one cycle: a write to the placement register, and the clock edge on which the write window closes. The bench provokes this by releasing reset, idling exactly 63 edges and then writing on edge 63. It then repeats the run with a write on edge 64 instead. The first run must show the moved RAM and register block, and the second must show the reset map. A second collision is between the register block and RAM on one shared base block. It is judged by probing either side of the 96-byte boundary right after that base is written.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

   typedef enum logic [1:0] {
      MODE_SINGLE = 2'd0,
      MODE_EXP    = 2'd1,
      MODE_BOOT   = 2'd2,
      MODE_TEST   = 2'd3
   } opmode_e;

   typedef struct packed {
      logic rboot;
      logic smod;
      logic mda;
   } modectl_t;

   localparam int SEL_REG  = 0;
   localparam int SEL_RAM  = 1;
   localparam int SEL_BOOT = 2;
   localparam int SEL_EE   = 3;
   localparam int SEL_EXT  = 4;
   localparam int NSEL     = 5;

   function automatic opmode_e pins_to_mode(input logic pb, input logic pa);
      case ({pb, pa})
         2'b10:   return MODE_SINGLE;
         2'b11:   return MODE_EXP;
         2'b00:   return MODE_BOOT;
         default: return MODE_TEST;
      endcase
   endfunction

   function automatic modectl_t mode_to_ctl(input opmode_e m);
      modectl_t c;
      case (m)
         MODE_SINGLE: c = '{rboot: 1'b0, smod: 1'b0, mda: 1'b0};
         MODE_EXP:    c = '{rboot: 1'b0, smod: 1'b0, mda: 1'b1};
         MODE_BOOT:   c = '{rboot: 1'b1, smod: 1'b1, mda: 1'b0};
         default:     c = '{rboot: 1'b0, smod: 1'b1, mda: 1'b1};
      endcase
      return c;
   endfunction

   function automatic logic has_ext_bus(input opmode_e m);
      return (m == MODE_EXP) || (m == MODE_TEST);
   endfunction

endpackage

// File: rtl/mm_mode_latch.sv
module mm_mode_latch
   import memmap_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     pin_b,
   input  logic     pin_a,
   output opmode_e  mode,
   output modectl_t ctl
);

   opmode_e mode_q;

   // Pins are sampled on every reset edge; the last one wins.
   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= pins_to_mode(pin_b, pin_a);
   end

   assign mode = mode_q;
   assign ctl  = mode_to_ctl(mode_q);

   // R9: once out of reset the mode never moves
   a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> $stable(mode_q))
      else $error("mode changed outside reset");

endmodule

// File: rtl/mm_map_reg.sv
module mm_map_reg #(
   parameter int BASE_W    = 4,
   parameter int DATA_W    = 8,
   parameter int WINDOW    = 64,
   parameter int MAP_RESET = 'h01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smod,
   input  logic              wr_hit,
   input  logic [DATA_W-1:0] wdata,
   output logic [BASE_W-1:0] ram_base,
   output logic [BASE_W-1:0] reg_base
);

   localparam int MAP_W = 2 * BASE_W;
   localparam int CNT_W = $clog2(WINDOW + 1);
   localparam logic [CNT_W-1:0] CNT_END = CNT_W'(WINDOW);
   localparam logic [MAP_W-1:0] RST_VAL = MAP_W'(MAP_RESET);

   initial begin
      assert (WINDOW > 0) else $error("WINDOW must be positive");
      assert (DATA_W >= MAP_W) else $error("DATA_W too narrow for both bases");
      assert (MAP_RESET < (1 << MAP_W)) else $error("MAP_RESET does not fit");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             used_q;
   logic [MAP_W-1:0] map_q;
   logic             closed;
   logic             accept;

   assign closed = (cnt_q == CNT_END);
   assign accept = wr_hit && (smod || (!used_q && !closed));

   // Saturating edge counter for the write window.
   always_ff @(posedge clk) begin
      if (!rst_n)       cnt_q <= '0;
      else if (!closed) cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         map_q  <= RST_VAL;
         used_q <= 1'b0;
      end else if (accept) begin
         map_q  <= wdata[MAP_W-1:0];
         used_q <= 1'b1;
      end
   end

   assign ram_base = map_q[MAP_W-1:BASE_W];
   assign reg_base = map_q[BASE_W-1:0];

   // R3: a used register is frozen in normal modes
   a_r3_write_once: assert property (@(posedge clk) disable iff (!rst_n)
      (!smod && used_q) |=> $stable(map_q))
      else $error("placement changed after first write");

   // R4: closed window freezes the register in normal modes
   a_r4_window_shut: assert property (@(posedge clk) disable iff (!rst_n)
      (!smod && closed) |=> $stable(map_q))
      else $error("placement changed after window");

   // R5: in special modes every write lands
   a_r5_special_write: assert property (@(posedge clk) disable iff (!rst_n)
      (smod && wr_hit) |=> (map_q == $past(wdata[MAP_W-1:0])))
      else $error("special-mode write lost");

endmodule

// File: rtl/mm_region_decode.sv
module mm_region_decode
   import memmap_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int BLOCK_W    = 12,
   parameter int RAM_BYTES  = 1024,
   parameter int REG_BYTES  = 96,
   parameter int EE_BYTES   = 512,
   parameter int BOOT_BASE  = 'hBF00,
   parameter int BOOT_BYTES = 256
) (
   input  logic [ADDR_W-1:0]         addr,
   input  logic [ADDR_W-BLOCK_W-1:0] ram_base,
   input  logic [ADDR_W-BLOCK_W-1:0] reg_base,
   input  logic [ADDR_W-BLOCK_W-1:0] ee_base,
   input  logic                      ee_en,
   input  opmode_e                   mode,
   output logic [NSEL-1:0]           sel
);

   localparam int BASE_W = ADDR_W - BLOCK_W;
   localparam int BLK_SZ = 1 << BLOCK_W;
   localparam logic [BLOCK_W:0] REG_LIM = (BLOCK_W+1)'(REG_BYTES);
   localparam logic [BLOCK_W:0] RAM_LIM = (BLOCK_W+1)'(RAM_BYTES);
   localparam logic [BLOCK_W:0] EE_LO   = (BLOCK_W+1)'(BLK_SZ - EE_BYTES);
   localparam logic [ADDR_W:0]  BOOT_LO = (ADDR_W+1)'(BOOT_BASE);
   localparam logic [ADDR_W:0]  BOOT_HI = (ADDR_W+1)'(BOOT_BASE + BOOT_BYTES);
   localparam logic [BASE_W-1:0] TOP_BLK = '1;

   initial begin
      assert (BASE_W > 0) else $error("BLOCK_W must be below ADDR_W");
      assert (RAM_BYTES <= BLK_SZ) else $error("RAM larger than a block");
      assert (REG_BYTES < RAM_BYTES) else $error("register block must be smaller than RAM");
      assert (EE_BYTES <= BLK_SZ) else $error("EEPROM larger than a block");
      assert (BOOT_BASE + BOOT_BYTES <= (1 << ADDR_W)) else $error("boot ROM past top");
   end

   logic [BLOCK_W:0]   ofs;
   logic [BASE_W-1:0]  blk;
   logic [BASE_W-1:0]  ee_blk;
   logic [NSEL-1:0]    hit;
   logic [NSEL:0]      taken;

   assign ofs    = {1'b0, addr[BLOCK_W-1:0]};
   assign blk    = addr[ADDR_W-1:BLOCK_W];
   assign ee_blk = has_ext_bus(mode) ? ee_base : TOP_BLK;

   assign hit[SEL_REG]  = (blk == reg_base) && (ofs < REG_LIM);
   assign hit[SEL_RAM]  = (blk == ram_base) && (ofs < RAM_LIM);
   assign hit[SEL_BOOT] = (mode == MODE_BOOT) &&
                          ({1'b0, addr} >= BOOT_LO) && ({1'b0, addr} < BOOT_HI);
   assign hit[SEL_EE]   = ee_en && (blk == ee_blk) && (ofs >= EE_LO);
   assign hit[SEL_EXT]  = has_ext_bus(mode);

   // Fixed-priority chain: lower index wins.
   assign taken[0] = 1'b0;
   for (genvar i = 0; i < NSEL; i++) begin : g_prio
      assign sel[i]     = hit[i] && !taken[i];
      assign taken[i+1] = taken[i] || hit[i];
   end

endmodule

// File: rtl/mem_map_decode.sv
module mem_map_decode
   import memmap_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter int BLOCK_W    = 12,
   parameter int RAM_BYTES  = 1024,
   parameter int REG_BYTES  = 96,
   parameter int EE_BYTES   = 512,
   parameter int BOOT_BASE  = 'hBF00,
   parameter int BOOT_BYTES = 256,
   parameter int WINDOW     = 64,
   parameter int MAP_RESET  = 'h01,
   parameter int MAP_OFS    = 'h03D
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        mode_b,
   input  logic                        mode_a,
   input  logic [ADDR_W-1:0]           addr,
   input  logic                        wr,
   input  logic [DATA_W-1:0]           wdata,
   input  logic [ADDR_W-BLOCK_W-1:0]   ee_base,
   input  logic                        ee_en,
   output logic [4:0]                  sel,
   output logic                        ctl_rboot,
   output logic                        ctl_smod,
   output logic                        ctl_mda
);

   localparam int BASE_W = ADDR_W - BLOCK_W;
   localparam logic [BLOCK_W-1:0] MAP_AT  = BLOCK_W'(MAP_OFS);
   localparam logic [BLOCK_W:0]   REG_LIM = (BLOCK_W+1)'(REG_BYTES);

   initial begin
      assert (MAP_OFS < REG_BYTES) else $error("placement register outside register block");
   end

   opmode_e           mode;
   modectl_t          ctl;
   logic [BASE_W-1:0] ram_base;
   logic [BASE_W-1:0] reg_base;
   logic [NSEL-1:0]   sel_int;
   logic              wr_hit;

   mm_mode_latch u_mode (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_b (mode_b),
      .pin_a (mode_a),
      .mode  (mode),
      .ctl   (ctl)
   );

   mm_region_decode #(
      .ADDR_W     (ADDR_W),
      .BLOCK_W    (BLOCK_W),
      .RAM_BYTES  (RAM_BYTES),
      .REG_BYTES  (REG_BYTES),
      .EE_BYTES   (EE_BYTES),
      .BOOT_BASE  (BOOT_BASE),
      .BOOT_BYTES (BOOT_BYTES)
   ) u_dec (
      .addr     (addr),
      .ram_base (ram_base),
      .reg_base (reg_base),
      .ee_base  (ee_base),
      .ee_en    (ee_en),
      .mode     (mode),
      .sel      (sel_int)
   );

   assign wr_hit = wr && sel_int[SEL_REG] && (addr[BLOCK_W-1:0] == MAP_AT);

   mm_map_reg #(
      .BASE_W    (BASE_W),
      .DATA_W    (DATA_W),
      .WINDOW    (WINDOW),
      .MAP_RESET (MAP_RESET)
   ) u_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .smod     (ctl.smod),
      .wr_hit   (wr_hit),
      .wdata    (wdata),
      .ram_base (ram_base),
      .reg_base (reg_base)
   );

   assign sel       = sel_int;
   assign ctl_rboot = ctl.rboot;
   assign ctl_smod  = ctl.smod;
   assign ctl_mda   = ctl.mda;

   // R10: never more than one region
   a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel))
      else $error("multiple regions selected");

   // R10: no external bus without one
   a_r10_no_ext: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.mda == 1'b0) |-> !sel[SEL_EXT])
      else $error("external select in a bus-less mode");

   // R8: boot ROM only in bootstrap mode
   a_r8_boot_mode: assert property (@(posedge clk) disable iff (!rst_n)
      sel[SEL_BOOT] |-> ctl.rboot)
      else $error("boot ROM outside bootstrap mode");

   // R7: EEPROM needs its enable
   a_r7_ee_enable: assert property (@(posedge clk) disable iff (!rst_n)
      sel[SEL_EE] |-> ee_en)
      else $error("EEPROM selected while disabled");

   // R6: registers shadow RAM when they share a block
   a_r6_reg_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ((addr[ADDR_W-1:BLOCK_W] == reg_base) &&
       ({1'b0, addr[BLOCK_W-1:0]} < REG_LIM)) |-> !sel[SEL_RAM])
      else $error("RAM answered inside register block");

endmodule

// File: tb/mem_map_decode_bench.sv
module mem_map_decode_bench;

   localparam int CLK_PERIOD = 10;
   localparam logic [4:0] S_NONE = 5'b00000;
   localparam logic [4:0] S_REG  = 5'b00001;
   localparam logic [4:0] S_RAM  = 5'b00010;
   localparam logic [4:0] S_BOOT = 5'b00100;
   localparam logic [4:0] S_EE   = 5'b01000;
   localparam logic [4:0] S_EXT  = 5'b10000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_b = 1'b1, mode_a = 1'b0;
   logic [15:0] addr = '0;
   logic        wr = 1'b0;
   logic [7:0]  wdata = '0;
   logic [3:0]  ee_base = '0;
   logic        ee_en = 1'b0;
   logic [4:0]  sel;
   logic        ctl_rboot, ctl_smod, ctl_mda;

   int n_chk = 0;
   int n_bad = 0;
   logic done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mem_map_decode u_mem_map_decode (
      .clk(clk), .rst_n(rst_n), .mode_b(mode_b), .mode_a(mode_a),
      .addr(addr), .wr(wr), .wdata(wdata), .ee_base(ee_base), .ee_en(ee_en),
      .sel(sel), .ctl_rboot(ctl_rboot), .ctl_smod(ctl_smod), .ctl_mda(ctl_mda)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic probe(input logic [15:0] a, input logic [4:0] exp, input string req);
      addr = a;
      #1;
      chk($sformatf("%s @%h", req, a), {11'b0, sel}, {11'b0, exp});
   endtask

   // Reset with pins b,a; pins flip right after release.
   task automatic do_reset(input logic b, input logic a);
      @(negedge clk);
      rst_n = 1'b0; mode_b = b; mode_a = a; wr = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1; mode_b = ~b; mode_a = ~a;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr_map(input logic [15:0] a, input logic [7:0] d);
      addr = a; wdata = d; wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic t_reset_map;
      do_reset(1'b1, 1'b0);
      chk("R9 single ctl", {13'b0, ctl_rboot, ctl_smod, ctl_mda}, 16'h0000);
      probe(16'h0000, S_RAM, "R1");
      probe(16'h03FF, S_RAM, "R1");
      probe(16'h1000, S_REG, "R1");
      probe(16'h105F, S_REG, "R1");
      probe(16'h0400, S_NONE, "R10 single");
      probe(16'h1060, S_NONE, "R10 single");
   endtask

   task automatic t_modes;
      do_reset(1'b1, 1'b1);
      chk("R9 expanded ctl", {13'b0, ctl_rboot, ctl_smod, ctl_mda}, 16'h0001);
      idle(5);
      chk("R9 pins ignored", {13'b0, ctl_rboot, ctl_smod, ctl_mda}, 16'h0001);
      do_reset(1'b0, 1'b0);
      chk("R9 boot ctl", {13'b0, ctl_rboot, ctl_smod, ctl_mda}, 16'h0006);
      do_reset(1'b0, 1'b1);
      chk("R9 test ctl", {13'b0, ctl_rboot, ctl_smod, ctl_mda}, 16'h0003);
   endtask

   task automatic t_ext;
      do_reset(1'b1, 1'b1);
      probe(16'h0400, S_EXT, "R10 expanded");
      probe(16'h1060, S_EXT, "R10 expanded");
      probe(16'h1000, S_REG, "R10 priority");
      do_reset(1'b1, 1'b0);
      probe(16'h8000, S_NONE, "R10 single");
   endtask

   task automatic t_remap_once;
      do_reset(1'b1, 1'b1);
      wr_map(16'h103D, 8'h23);
      probe(16'h2000, S_RAM, "R2");
      probe(16'h0000, S_EXT, "R2");
      probe(16'h3000, S_REG, "R2");
      probe(16'h1000, S_EXT, "R2");
      wr_map(16'h303D, 8'h45);
      probe(16'h2000, S_RAM, "R3");
      probe(16'h3000, S_REG, "R3");
      probe(16'h4000, S_EXT, "R3");
   endtask

   task automatic t_window;
      do_reset(1'b1, 1'b1);
      idle(63);
      wr_map(16'h103D, 8'h50);
      probe(16'h5000, S_RAM, "R4 edge63");
      probe(16'h0000, S_REG, "R4 edge63");
      do_reset(1'b1, 1'b1);
      idle(64);
      wr_map(16'h103D, 8'h50);
      probe(16'h0000, S_RAM, "R4 edge64");
      probe(16'h1000, S_REG, "R4 edge64");
      probe(16'h5000, S_EXT, "R4 edge64");
   endtask

   task automatic t_overlap;
      do_reset(1'b1, 1'b1);
      wr_map(16'h103D, 8'h22);
      probe(16'h2000, S_REG, "R6");
      probe(16'h205F, S_REG, "R6");
      probe(16'h2060, S_RAM, "R6");
      probe(16'h23FF, S_RAM, "R6");
      probe(16'h2400, S_EXT, "R6");
   endtask

   task automatic t_special;
      do_reset(1'b0, 1'b1);
      wr_map(16'h103D, 8'h30);
      probe(16'h3000, S_RAM, "R5 first");
      probe(16'h0000, S_REG, "R5 first");
      idle(100);
      wr_map(16'h003D, 8'h74);
      probe(16'h7000, S_RAM, "R5 late");
      probe(16'h4000, S_REG, "R5 late");
      probe(16'h0000, S_EXT, "R5 late");
   endtask

   task automatic t_eeprom;
      do_reset(1'b0, 1'b1);
      ee_base = 4'h4; ee_en = 1'b1;
      probe(16'h4E00, S_EE, "R7 test");
      probe(16'h4FFF, S_EE, "R7 test");
      probe(16'h4DFF, S_EXT, "R7 test");
      probe(16'hFE00, S_EXT, "R7 test");
      ee_en = 1'b0;
      probe(16'h4E00, S_EXT, "R7 disabled");
      do_reset(1'b1, 1'b0);
      ee_en = 1'b1;
      probe(16'hFE00, S_EE, "R7 single");
      probe(16'hFFFF, S_EE, "R7 single");
      probe(16'h4E00, S_NONE, "R7 single");
      ee_en = 1'b0;
      probe(16'hFE00, S_NONE, "R7 disabled");
   endtask

   task automatic t_boot;
      do_reset(1'b0, 1'b0);
      ee_en = 1'b1; ee_base = 4'hB;
      probe(16'hBF00, S_BOOT, "R8 boot");
      probe(16'hBFFF, S_BOOT, "R8 boot");
      probe(16'hBEFF, S_NONE, "R8 boot");
      probe(16'hFE00, S_EE, "R7 boot");
      do_reset(1'b1, 1'b1);
      ee_en = 1'b0;
      probe(16'hBF00, S_EXT, "R8 expanded");
      do_reset(1'b0, 1'b1);
      probe(16'hBF00, S_EXT, "R8 test");
      ee_en = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      t_reset_map();
      t_modes();
      t_ext();
      t_remap_once();
      t_window();
      t_overlap();
      t_special();
      t_eeprom();
      t_boot();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule